// File: doc/BRIEF.md
# Staged Display Register Bank

This block holds the settings and the picture of an LED matrix display. A bus front end hands it single-byte writes as address and data, and it keeps the state that a row/column scanner and an analog intensity stage read. One byte sets the panel geometry, the global blanking flag and whether audio modulates the brightness. Eleven bytes hold the lit/unlit pattern of each column. One byte holds the audio gain code and the full-scale current code. One byte turns on the equalizer display.

Column bytes are double-buffered. A write to a column address lands only in a staging copy, and the scanner never sees it there. When the value zero is written to the update address, the whole staging image moves into the active copy in one clock. So software can rebuild a frame column by column and the viewer never sees half a frame. Every stored field is a flop that clears on reset, and blanking the panel leaves the stored state as it was.

Top module: `disp_regbank`

## Requirements
- R1: After reset every output is zero: geometry code 0 (8 rows by 8 columns), not blanked, audio modulation off, gain code 0, current code 0, equalizer off, every active column bit 0.
- R2: A write to address 00h sets `blank` from data bit 7, `audio_mod_en` from bit 2 and `geom` from bits 1:0. Bits 6:3 are dropped. The outputs change on the clock edge that takes the write.
- R3: A write to address N, with N from 01h to 0Bh, stores its byte as the staged image of column N, and `col_rows` does not change because of it.
- R4: A write of data 00h to address 0Ch copies all eleven staged columns into `col_rows` on the clock edge that takes the write.
- R5: A write of any nonzero data to address 0Ch leaves `col_rows` and the staged image unchanged.
- R6: A write to address 0Dh sets `gain_sel` from data bits 6:4 and `cur_sel` from bits 3:0. Bit 7 is dropped.
- R7: A write to address 0Fh sets `eq_en` from data bit 6. All other bits are dropped.
- R8: A write to address 0Eh or to any address from 10h to FFh changes no output and no staged column.
- R9: Writing the blanking bit, whether it enters or leaves blanking, leaves the gain, current, equalizer and all column state (active and staged) unchanged.
- R10: In `col_rows`, column N (N = 1..11) sits in bits 8*(N-1)+7 down to 8*(N-1). Within a column, bit 0 is row 1 and bit 7 is row 8.
- R11: A commit leaves the staged image unchanged, so a second commit with no column writes between gives the same `col_rows`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| geom | output | 2 | Panel geometry code |
| blank | output | 1 | Global blanking (shutdown) flag |
| audio_mod_en | output | 1 | Audio modulation of brightness |
| gain_sel | output | 3 | Audio input gain code |
| cur_sel | output | 4 | Full-scale current code |
| eq_en | output | 1 | Equalizer display enable |
| col_rows | output | 88 | Active column image, column 1 in the low byte |

## Verification
Every state element drives an output or feeds the commit path, so a wrong control field shows on its output port in the cycle after the write that caused it. A staged column that was corrupted or lost stays hidden until the next commit. The sweeps therefore follow every pass over the column addresses with a commit, and compare all 88 active bits. A stray commit caused by a nonzero update write, or by a mis-decoded address, shows as an early change of `col_rows` in the cycle after that write.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CFG   = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_COL0  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_UPD   = 8'h0C;
    localparam logic [ADDR_W-1:0] ADR_LIGHT = 8'h0D;
    localparam logic [ADDR_W-1:0] ADR_EQ    = 8'h0F;

    // bit positions decoded by neighbours
    localparam int CFG_BLANK_BIT = 7;
    localparam int CFG_AUDIO_BIT = 2;
    localparam int EQ_EN_BIT     = 6;

    typedef struct packed {
        logic       blank;
        logic       audio;
        logic [1:0] geom;
    } cfg_t;

    typedef struct packed {
        logic [2:0] gain;
        logic [3:0] cur;
    } light_t;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import dispreg_pkg::*;
#(
    parameter int NCOL = 11
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cfg_we,
    output logic [NCOL-1:0]   col_we,
    output logic              commit,
    output logic              light_we,
    output logic              eq_we,
    output logic              unlisted
);

    logic upd_hit;

    always_comb begin
        cfg_we   = wr_en && (wr_addr == ADR_CFG);
        upd_hit  = wr_en && (wr_addr == ADR_UPD);
        commit   = upd_hit && (wr_data == '0);
        light_we = wr_en && (wr_addr == ADR_LIGHT);
        eq_we    = wr_en && (wr_addr == ADR_EQ);
    end

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign col_we[c] = wr_en && (wr_addr == ADR_COL0 + ADDR_W'(c));
    end

    assign unlisted = wr_en && !cfg_we && !(|col_we) && !upd_hit
                      && !light_we && !eq_we;

endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
    import dispreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              light_we,
    input  logic              eq_we,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg,
    output light_t            light,
    output logic              eq_en
);

    typedef struct packed {
        cfg_t   cfg;
        light_t light;
        logic   eq;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg.blank = wr_data[CFG_BLANK_BIT];
            st_d.cfg.audio = wr_data[CFG_AUDIO_BIT];
            st_d.cfg.geom  = wr_data[1:0];
        end
        if (light_we) begin
            st_d.light.gain = wr_data[6:4];
            st_d.light.cur  = wr_data[3:0];
        end
        if (eq_we) begin
            st_d.eq = wr_data[EQ_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg   = st_q.cfg;
    assign light = st_q.light;
    assign eq_en = st_q.eq;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.cfg)); // R2
    AST_BLANK_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !light_we && !eq_we) |=> ($stable(st_q.light) && $stable(st_q.eq))); // R9
    AST_LIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !light_we |=> $stable(st_q.light)); // R6
    AST_EQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eq_we |=> $stable(st_q.eq)); // R7

endmodule

// File: rtl/regbank_colbuf.sv
module regbank_colbuf
    import dispreg_pkg::*;
#(
    parameter int NCOL  = 11,
    parameter int ROW_W = DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCOL-1:0]       col_we,
    input  logic                  commit,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NCOL*ROW_W-1:0] active_flat
);

    localparam int IMG_W = NCOL * ROW_W;

    typedef struct packed {
        logic [NCOL-1:0][ROW_W-1:0] stage;
        logic [NCOL-1:0][ROW_W-1:0] active;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCOL; c++) begin
            if (col_we[c]) st_d.stage[c] = wr_data[ROW_W-1:0];
        end
        if (commit) st_d.active = st_q.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_flat = IMG_W'(st_q.active);

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_flat)); // R5
    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_flat == IMG_W'($past(st_q.stage)))); // R4
    AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || !(|col_we)) |=> $stable(st_q.stage)); // R11

endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
    import dispreg_pkg::*;
#(
    parameter int NCOL  = 11,
    parameter int ROW_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    output logic [1:0]            geom,
    output logic                  blank,
    output logic                  audio_mod_en,
    output logic [2:0]            gain_sel,
    output logic [3:0]            cur_sel,
    output logic                  eq_en,
    output logic [NCOL*ROW_W-1:0] col_rows
);

    logic            cfg_we, commit, light_we, eq_we, unlisted;
    logic [NCOL-1:0] col_we;
    cfg_t            cfg;
    light_t          light;

    regbank_decode #(.NCOL(NCOL)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_we   (cfg_we),
        .col_we   (col_we),
        .commit   (commit),
        .light_we (light_we),
        .eq_we    (eq_we),
        .unlisted (unlisted)
    );

    regbank_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .light_we (light_we),
        .eq_we    (eq_we),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .light    (light),
        .eq_en    (eq_en)
    );

    regbank_colbuf #(.NCOL(NCOL), .ROW_W(ROW_W)) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_we      (col_we),
        .commit      (commit),
        .wr_data     (wr_data),
        .active_flat (col_rows)
    );

    assign geom         = cfg.geom;
    assign blank        = cfg.blank;
    assign audio_mod_en = cfg.audio;
    assign gain_sel     = light.gain;
    assign cur_sel      = light.cur;

    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_we, col_we, commit, light_we, eq_we, unlisted})); // R8
    AST_UNLISTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        unlisted |=> ($stable(col_rows) && $stable(cfg) && $stable(light)
                      && $stable(eq_en))); // R8

endmodule

// File: tb/test_disp_regbank.sv
module test_disp_regbank;

    localparam int NCOL = 11;
    localparam int IMG  = NCOL * 8;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           wr_en = 0;
    logic [7:0]     wr_addr = 0;
    logic [7:0]     wr_data = 0;
    logic [1:0]     geom;
    logic           blank, audio_mod_en, eq_en;
    logic [2:0]     gain_sel;
    logic [3:0]     cur_sel;
    logic [IMG-1:0] col_rows;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    logic [1:0]     m_geom = 0;
    logic           m_blank = 0, m_aud = 0, m_eq = 0;
    logic [2:0]     m_gain = 0;
    logic [3:0]     m_cur = 0;
    logic [IMG-1:0] m_stage = 0, m_active = 0;

    always #10 clk = ~clk;

    disp_regbank i_disp_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .geom(geom), .blank(blank),
        .audio_mod_en(audio_mod_en), .gain_sel(gain_sel), .cur_sel(cur_sel),
        .eq_en(eq_en), .col_rows(col_rows)
    );

    task automatic chk(string tag, string what, logic [IMG-1:0] act, logic [IMG-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, "geom",  IMG'(geom),         IMG'(m_geom));
        chk(tag, "blank", IMG'(blank),        IMG'(m_blank));
        chk(tag, "audio", IMG'(audio_mod_en), IMG'(m_aud));
        chk(tag, "gain",  IMG'(gain_sel),     IMG'(m_gain));
        chk(tag, "cur",   IMG'(cur_sel),      IMG'(m_cur));
        chk(tag, "eq",    IMG'(eq_en),        IMG'(m_eq));
        chk(tag, "cols",  col_rows,           m_active);
    endtask

    task automatic model(logic [7:0] a, logic [7:0] d);
        if (a == 8'h00) begin                       // R2
            m_blank = d[7]; m_aud = d[2]; m_geom = d[1:0];
        end else if (a >= 8'h01 && a <= 8'h0B) begin // R3, R10
            m_stage[(int'(a) - 1) * 8 +: 8] = d;
        end else if (a == 8'h0C) begin              // R4, R5
            if (d == 8'h00) m_active = m_stage;
        end else if (a == 8'h0D) begin              // R6
            m_gain = d[6:4]; m_cur = d[3:0];
        end else if (a == 8'h0F) begin              // R7
            m_eq = d[6];
        end                                         // R8: others ignored
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model(a, d);
    endtask

    function automatic string tag_of(int a);
        if (a == 0)                return "R2";
        if (a >= 1 && a <= 11)     return "R3";
        if (a == 12)               return "R5";
        if (a == 13)               return "R6";
        if (a == 15)               return "R7";
        return "R8";
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1");
        rst_n = 1;
        @(negedge clk);
        chk_all("R1");

        // sweep 1: every address, one data pattern; 0Ch gets nonzero data
        for (int a = 0; a < 256; a++) begin
            wr(8'(a), 8'((a * 37 + 5) & 255));
            chk_all(tag_of(a));
        end
        wr(8'h0C, 8'h00);
        chk_all("R4");
        wr(8'h0C, 8'h00);
        chk_all("R11");

        // blanking on and off keeps everything else
        wr(8'h0F, 8'h40);
        wr(8'h0D, 8'h5A);
        wr(8'h00, 8'h80);
        chk_all("R9");
        wr(8'h00, 8'h03);
        chk_all("R9");
        wr(8'h0C, 8'h00);
        chk_all("R9");

        // sweep 2: inverted-ish pattern, commits between passes
        for (int a = 255; a >= 0; a--) begin
            wr(8'(a), 8'(((a * 73 + 11) & 255) ^ 8'hA5));
            chk_all(tag_of(a));
        end
        for (int d = 1; d < 256; d += 17) begin
            wr(8'h0C, 8'(d));
            chk_all("R5");
        end
        wr(8'h0C, 8'h00);
        chk_all("R4");

        // mapping: row 1 of column 1 and row 8 of column 11
        for (int c = 1; c <= 11; c++) wr(8'(c), 8'h00);
        wr(8'h01, 8'h01);
        wr(8'h0B, 8'h80);
        wr(8'h0C, 8'h00);
        chk("R10", "col1 row1", IMG'(col_rows[0]), IMG'(1));
        chk("R10", "col11 row8", IMG'(col_rows[87]), IMG'(1));
        chk("R10", "bit count", IMG'($countones(col_rows)), IMG'(2));
        chk_all("R10");

        // unlisted addresses with all ones, then stage-only write
        wr(8'h0E, 8'hFF);
        wr(8'hFF, 8'hFF);
        wr(8'h10, 8'hFF);
        chk_all("R8");
        wr(8'h06, 8'hFF);
        chk_all("R3");

        // reset again clears all
        @(negedge clk);
        rst_n = 0;
        m_geom = 0; m_blank = 0; m_aud = 0; m_eq = 0; m_gain = 0; m_cur = 0;
        m_stage = 0; m_active = 0;
        @(negedge clk);
        chk_all("R1");
        rst_n = 1;
        wr(8'h0C, 8'h00);
        chk_all("R1");

        done = 1;
        finish_run();
    end

endmodule